// File: doc/BRIEF.md
# Accumulator ALU with Registered Status Flags

This block is the arithmetic and logic datapath that sits between an accumulator and a temporary operand register. Each cycle it takes the accumulator value, the temporary operand, a four-bit operation code and an incoming carry. It returns the result in the same cycle, together with a strobe that tells the surrounding datapath whether the result should be written back into the accumulator.

Five status bits are derived from every result: sign, zero, nibble carry, even parity and carry/borrow. They are captured in a flag register on the rising clock edge whenever the flag-write enable is high. Each operation class updates only its own subset of flags. The flags are presented as one packed status byte that includes fixed filler bits.

Top module: `acc_alu`

## Requirements
- R1: Op codes 0 (add), 1 (add with carry-in), 2 (subtract) and 3 (subtract with carry-in as borrow) give `result_o` = acc+tmp, acc+tmp+cin, acc−tmp and acc−tmp−cin, all modulo 256, in the same cycle.
- R2: Op codes 4, 5, 6 and 10 give acc AND tmp, acc XOR tmp, acc OR tmp and NOT acc. Op 10 changes no flag.
- R3: Op codes 11 to 14 rotate the accumulator: 11 left circular, 12 right circular, 13 left through `cin_i`, 14 right through `cin_i`. The bit shifted out goes to CY, and no other flag changes.
- R4: Op code 8 gives acc+1 and op code 9 gives acc−1, both modulo 256.
- R5: After an update by any arithmetic, compare, logic, increment or decrement op, S equals bit 7 of the result and Z is 1 exactly when the result is 0x00.
- R6: For those same ops, P is 1 when the result holds an even number of ones.
- R7: AC is the carry out of bit 3 of the internal sum. Subtraction forms acc + NOT tmp + (1 − borrow-in), increment adds one, and decrement adds 0xFF.
- R8: CY is the carry out of bit 7 for ops 0 and 1, and the borrow (acc < tmp + borrow-in) for ops 2, 3 and 7.
- R9: AND sets AC to 1. XOR and OR clear AC. All three clear CY.
- R10: Increment and decrement leave CY at its previous value. Op 15 changes no flag and passes the accumulator through.
- R11: Compare (op 7) updates the flags exactly as op 2 does. `wr_acc_o` is 0 for op 7 and op 15 and 1 for every other op.
- R12: `flags_o` is {S, Z, 0, AC, 0, P, 1, CY} from bit 7 down to bit 0. A synchronous active-low reset clears all five flags, so the byte reads 0x02.
- R13: The flags change only on a rising edge where `flag_we_i` is 1. With `flag_we_i` at 0 the byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| tmp_i | input | 8 | Temporary-register operand |
| cin_i | input | 1 | Incoming carry / borrow / rotate fill bit |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Operation result |
| wr_acc_o | output | 1 | Accumulator write-back strobe |
| flags_o | output | 8 | Packed status byte |

## Verification
The bench builds the block at its default eight-bit data width, where every operand value can be enumerated. All 256 accumulator values are swept through every single-operand op with both carry-in values. The two-operand ops pair all 256 accumulator values with a stride of tmp values, so every nibble-carry, borrow and wrap boundary is reached. Flag-write enable is dropped on a regular fraction of steps, and the flags left by the previous step vary, so held carry and held-byte behaviour are both exercised.

// File: rtl/acc_alu_pkg.sv
// Shared definitions for the accumulator ALU: operation codes and the
// positions of the five flags inside the internal flag vector.
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_AND  = 4'd4,
        OP_XOR  = 4'd5,
        OP_OR   = 4'd6,
        OP_CMP  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_NOT  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_ROLC = 4'd13,
        OP_RORC = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    // Internal five-bit flag vector indices
    localparam int FI_CY  = 0;
    localparam int FI_P   = 1;
    localparam int FI_AC  = 2;
    localparam int FI_Z   = 3;
    localparam int FI_S   = 4;
    localparam int NFLAGS = 5;

    // Positions in the packed status byte
    localparam int FB_CY  = 0;
    localparam int FB_ONE = 1;
    localparam int FB_P   = 2;
    localparam int FB_AC  = 4;
    localparam int FB_Z   = 6;
    localparam int FB_S   = 7;

endpackage

// File: rtl/acc_alu_arith.sv
// Adder path of the ALU: add, add with carry, subtract, subtract with
// borrow, compare, increment and decrement. It is built as a low half and a
// high half, so the nibble carry is available without a second adder.
// Assumes DATA_W is even. Carry out is reported as a borrow for subtraction.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              half_c,
    output logic              cy_out
);
    localparam int LO_W = DATA_W / 2;
    localparam int HI_W = DATA_W - LO_W;

    logic [DATA_W-1:0] y;
    logic              c0;
    logic              is_sub;
    logic [LO_W:0]     lo;
    logic [HI_W:0]     hi;

    // Pick the second addend and the carry into bit 0 for each op
    always_comb begin
        y      = b;
        c0     = 1'b0;
        is_sub = 1'b0;
        case (op)
            OP_ADD:         begin y = b;  c0 = 1'b0; end
            OP_ADDC:        begin y = b;  c0 = cin;  end
            OP_SUB, OP_CMP: begin y = ~b; c0 = 1'b1; is_sub = 1'b1; end
            OP_SUBB:        begin y = ~b; c0 = ~cin; is_sub = 1'b1; end
            OP_INC:         begin y = '0; c0 = 1'b1; end
            OP_DEC:         begin y = '1; c0 = 1'b0; end
            default:        begin y = b;  c0 = 1'b0; end
        endcase
    end

    // Two-stage addition: the low half feeds its carry into the high half
    always_comb begin
        lo     = {1'b0, a[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} + {{LO_W{1'b0}}, c0};
        hi     = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, y[DATA_W-1:LO_W]}
                 + {{HI_W{1'b0}}, lo[LO_W]};
        sum    = {hi[HI_W-1:0], lo[LO_W-1:0]};
        half_c = lo[LO_W];
        cy_out = is_sub ? ~hi[HI_W] : hi[HI_W];
    end

endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise and rotate path of the ALU. Rotates act on the accumulator operand
// only. For the through-carry forms the fill bit is the incoming carry.
// rot_cy carries the bit shifted out.
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              rot_cy
);
    localparam int MSB = DATA_W - 1;

    // Select the bitwise or rotate result
    always_comb begin
        res    = a;
        rot_cy = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_NOT:  res = ~a;
            OP_ROL:  begin res = {a[MSB-1:0], a[MSB]}; rot_cy = a[MSB]; end
            OP_ROR:  begin res = {a[0], a[MSB:1]};     rot_cy = a[0];   end
            OP_ROLC: begin res = {a[MSB-1:0], cin};    rot_cy = a[MSB]; end
            OP_RORC: begin res = {cin, a[MSB:1]};      rot_cy = a[0];   end
            default: begin res = a; rot_cy = 1'b0; end
        endcase
    end

endmodule

// File: rtl/acc_alu_flagreg.sv
// Five-bit flag register with a per-flag update mask. A flag loads its new
// value only when the global write enable and its own mask bit are both high.
// Reset is synchronous and active low, and clears every flag.
module acc_alu_flagreg
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NFLAGS-1:0] mask,
    input  logic [NFLAGS-1:0] next,
    output logic [NFLAGS-1:0] q
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        // One flip-flop per flag, loaded under its mask bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (we && mask[i])
                q[i] <= next[i];
        end
    end

    // R13: a cycle without write enable leaves every flag untouched
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/acc_alu.sv
// Top of the accumulator ALU. It decodes the op code into a datapath
// selection, a set of flags to update and the accumulator write strobe. It
// derives the flag values from the selected result and packs the registered
// flags into the status byte. Result and strobe are combinational. Only the
// flags are registered.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] tmp_i,
    input  logic              cin_i,
    input  logic              flag_we_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_acc_o,
    output logic [7:0]        flags_o
);
    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic [DATA_W-1:0] ar_sum;
    logic              ar_half;
    logic              ar_cy;
    logic [DATA_W-1:0] lg_res;
    logic              lg_cy;
    logic              use_arith;
    logic [NFLAGS-1:0] upd_mask;
    logic [NFLAGS-1:0] next_flags;
    logic [NFLAGS-1:0] flags_q;

    assign op = alu_op_e'(op_i);

    acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op     (op),
        .a      (acc_i),
        .b      (tmp_i),
        .cin    (cin_i),
        .sum    (ar_sum),
        .half_c (ar_half),
        .cy_out (ar_cy)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op     (op),
        .a      (acc_i),
        .b      (tmp_i),
        .cin    (cin_i),
        .res    (lg_res),
        .rot_cy (lg_cy)
    );

    // Decode: datapath select, flag update mask and write-back strobe
    always_comb begin
        use_arith = 1'b0;
        upd_mask  = '0;
        wr_acc_o  = 1'b1;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                use_arith = 1'b1;
                upd_mask  = '1;
            end
            OP_CMP: begin
                use_arith = 1'b1;
                upd_mask  = '1;
                wr_acc_o  = 1'b0;
            end
            OP_INC, OP_DEC: begin
                use_arith = 1'b1;
                upd_mask  = '1;
                upd_mask[FI_CY] = 1'b0;
            end
            OP_AND, OP_XOR, OP_OR: upd_mask = '1;
            OP_ROL, OP_ROR, OP_ROLC, OP_RORC: upd_mask[FI_CY] = 1'b1;
            OP_NOT: upd_mask = '0;
            OP_NOP: wr_acc_o = 1'b0;
            default: upd_mask = '0;
        endcase
    end

    assign result_o = use_arith ? ar_sum : lg_res;

    // Flag values computed from the selected result
    always_comb begin
        next_flags        = '0;
        next_flags[FI_S]  = result_o[MSB];
        next_flags[FI_Z]  = (result_o == '0);
        next_flags[FI_P]  = ~(^result_o);
        if (use_arith) begin
            next_flags[FI_AC] = ar_half;
            next_flags[FI_CY] = ar_cy;
        end else begin
            next_flags[FI_AC] = (op == OP_AND);
            next_flags[FI_CY] = lg_cy;
        end
    end

    acc_alu_flagreg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we_i),
        .mask  (upd_mask),
        .next  (next_flags),
        .q     (flags_q)
    );

    // Pack the status byte with its fixed filler bits
    always_comb begin
        flags_o         = 8'h00;
        flags_o[FB_S]   = flags_q[FI_S];
        flags_o[FB_Z]   = flags_q[FI_Z];
        flags_o[FB_AC]  = flags_q[FI_AC];
        flags_o[FB_P]   = flags_q[FI_P];
        flags_o[FB_ONE] = 1'b1;
        flags_o[FB_CY]  = flags_q[FI_CY];
    end

    // R11: compare returns the plain difference and never requests write-back
    p_cmp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> (!wr_acc_o && result_o == DATA_W'(acc_i - tmp_i)));

    // R5: zero flag follows the result that was written
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && upd_mask[FI_Z]) |=> (flags_o[FB_Z] == ($past(result_o) == '0)));

    // R5: sign flag follows the top result bit
    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && upd_mask[FI_S]) |=> (flags_o[FB_S] == $past(result_o[MSB])));

    // R6: parity flag is high for an even count of ones
    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && upd_mask[FI_P]) |=> (flags_o[FB_P] == ($countones($past(result_o)) % 2 == 0)));

    // R9: logic ops leave the carry flag clear
    p_logic_cy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op == OP_AND || op == OP_XOR || op == OP_OR)) |=> !flags_o[FB_CY]);

    // R10: increment and decrement keep the previous carry
    p_keep_cy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op == OP_INC || op == OP_DEC)) |=> $stable(flags_o[FB_CY]));

    // R12: filler bits of the status byte never move
    p_filler_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FB_ONE] && !flags_o[3] && !flags_o[5]);

endmodule

// File: tb/acc_alu_test.sv
// Sweep bench for the accumulator ALU at eight-bit width.
module acc_alu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] tmp_i = 8'd0;
    logic       cin_i = 1'b0;
    logic       flag_we_i = 1'b0;
    logic [7:0] result_o;
    logic       wr_acc_o;
    logic [7:0] flags_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    // model flags: [4]=S [3]=Z [2]=AC [1]=P [0]=CY
    logic [4:0] mf = 5'b0;

    always #2 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .tmp_i(tmp_i),
        .cin_i(cin_i), .flag_we_i(flag_we_i), .result_o(result_o),
        .wr_acc_o(wr_acc_o), .flags_o(flags_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (op %0d acc 0x%0h tmp 0x%0h cin %0d)",
                     tag, act, exp, op_i, acc_i, tmp_i, cin_i);
        end
    endtask

    function automatic bit even_ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2) == 0;
    endfunction

    function automatic string res_tag(input int op);
        if (op <= 3) return "R1";
        if (op == 7) return "R11";
        if (op == 8 || op == 9) return "R4";
        if (op >= 11 && op <= 14) return "R3";
        if (op == 15) return "R10";
        return "R2";
    endfunction

    // Reference model computed arithmetically from the requirements
    task automatic model(input int op, input int a, input int b, input int c,
                         output int r, output bit wr, output logic [4:0] nf);
        int t;
        bit ac, cy, u_szp, u_ac, u_cy;
        int bin;
        ac = 0; cy = 0; u_szp = 0; u_ac = 0; u_cy = 0; wr = 1; r = a;
        case (op)
            0, 1: begin
                bin = (op == 1) ? c : 0;
                t = a + b + bin; r = t % 256; cy = t > 255;
                ac = ((a % 16) + (b % 16) + bin) > 15;
                u_szp = 1; u_ac = 1; u_cy = 1;
            end
            2, 3, 7: begin
                bin = (op == 3) ? c : 0;
                t = a - b - bin; cy = t < 0; r = (t + 512) % 256;
                ac = ((a % 16) + (15 - (b % 16)) + (1 - bin)) > 15;
                u_szp = 1; u_ac = 1; u_cy = 1; wr = (op != 7);
            end
            4: begin r = a & b; ac = 1; cy = 0; u_szp = 1; u_ac = 1; u_cy = 1; end
            5: begin r = a ^ b; ac = 0; cy = 0; u_szp = 1; u_ac = 1; u_cy = 1; end
            6: begin r = a | b; ac = 0; cy = 0; u_szp = 1; u_ac = 1; u_cy = 1; end
            8: begin r = (a + 1) % 256;   ac = (a % 16) == 15; u_szp = 1; u_ac = 1; end
            9: begin r = (a + 255) % 256; ac = (a % 16) != 0;  u_szp = 1; u_ac = 1; end
            10: r = 255 - a;
            11: begin r = (a * 2) % 256 + a / 128; cy = a / 128; u_cy = 1; end
            12: begin r = a / 2 + (a % 2) * 128;   cy = a % 2;   u_cy = 1; end
            13: begin r = (a * 2) % 256 + c;       cy = a / 128; u_cy = 1; end
            14: begin r = a / 2 + c * 128;         cy = a % 2;   u_cy = 1; end
            default: begin r = a; wr = 0; end
        endcase
        nf = mf;
        if (u_szp) begin
            nf[4] = r >= 128;
            nf[3] = r == 0;
            nf[1] = even_ones(r);
        end
        if (u_ac) nf[2] = ac;
        if (u_cy) nf[0] = cy;
    endtask

    // One operation: drive, check combinational outputs, then registered flags
    task automatic step(input int op, input int a, input int b, input int c, input bit we);
        int r; bit wr; logic [4:0] nf; logic [7:0] eb;
        string tac, tcy;
        op_i = 4'(op); acc_i = 8'(a); tmp_i = 8'(b); cin_i = c[0]; flag_we_i = we;
        #1;
        model(op, a, b, c, r, wr, nf);
        chk(result_o == 8'(r), res_tag(op), result_o, r);
        chk(wr_acc_o == wr, "R11", wr_acc_o, wr);
        if (we) mf = nf;
        @(posedge clk);
        @(negedge clk);
        eb = {mf[4], mf[3], 1'b0, mf[2], 1'b0, mf[1], 1'b1, mf[0]};
        tac = (op >= 4 && op <= 6) ? "R9" : "R7";
        tcy = (op >= 4 && op <= 6) ? "R9" :
              (op >= 11 && op <= 14) ? "R3" :
              (op <= 3 || op == 7) ? "R8" : "R10";
        if (!we) begin tac = "R13"; tcy = "R13"; end
        chk(flags_o[7] == eb[7], we ? "R5" : "R13", flags_o[7], eb[7]);
        chk(flags_o[6] == eb[6], we ? "R5" : "R13", flags_o[6], eb[6]);
        chk(flags_o[2] == eb[2], we ? "R6" : "R13", flags_o[2], eb[2]);
        chk(flags_o[4] == eb[4], tac, flags_o[4], eb[4]);
        chk(flags_o[0] == eb[0], tcy, flags_o[0], eb[0]);
        chk(flags_o == eb, "R12", flags_o, eb);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(flags_o == 8'h02, "R12", flags_o, 8'h02);
        // single-operand ops: every accumulator value, both carry-in values
        for (int op = 8; op < 16; op++)
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 256; a++)
                    step(op, a, (a * 37) % 256, c, (a % 9) != 4);
        // two-operand ops: every accumulator value against a stride of tmp values
        for (int op = 0; op < 8; op++)
            for (int b = 0; b < 256; b += 7)
                for (int a = 0; a < 256; a++)
                    step(op, a, b, (a ^ (b >> 1)) & 1, ((a + b) % 11) != 3);
        // corner cases named explicitly
        step(0, 255, 1, 0, 1);   // R8 carry and R5 zero
        step(2, 0, 1, 0, 1);     // R8 borrow
        step(3, 16, 0, 1, 1);    // R7 nibble borrow path
        step(7, 42, 42, 0, 1);   // R11 compare equal
        step(8, 255, 0, 0, 0);   // R13 hold
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule